// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines, holds each rising edge in a request register, and filters the held requests through a mask register. Input 0 has the highest priority. A pending, unmasked request raises the interrupt output to the processor only when it outranks everything already in service. The processor answers with two acknowledge pulses. The first pulse moves the winning request into the in-service register. The second pulse delivers an 8-bit vector made of a programmed base and the input number. In a master, an input may instead be routed to a downstream controller.

Software talks to the block through a two-address register port: a command address (`bus_addr` = 0) and a data address (`bus_addr` = 1). A command write with bit 4 set starts a configuration sequence, and the data writes that follow fill in the configuration. Other command writes do one of two things:
- end an interrupt, either a named one or the highest one in service;
- choose which register a command-address read returns.

Once configuration is complete, data writes load the mask.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the interrupt output, `vec_valid` and `cas_active` are low, the controller is unconfigured, and a data-address read returns 0xFF (all inputs masked; mask bit i = 1 masks input i).
- R2: A command write with bit 4 set starts configuration. It clears the request and in-service registers and selects the request register for reads. The next data write is the vector base. Then comes a cascade word, unless bit 1 of the start command was 1. Then comes a mode word, only if bit 0 of the start command was 1. The interrupt output stays low until the last expected word is written.
- R3: Outside configuration, a data write loads the mask and a data read returns it. A masked input is still held in the request register but never raises the interrupt output.
- R4: A rising edge on an input sets its request bit, and the bit clears if the line falls before acknowledge. The interrupt output is high when some unmasked request has a lower index than every set in-service bit and no acknowledge is in progress.
- R5: A command write of 0x0A makes command-address reads return the request register. A command write of 0x0B makes them return the in-service register. The choice persists until changed.
- R6: The first acknowledge pulse clears the winning request bit and sets its in-service bit. After the second pulse, `vec_valid` is high for one cycle, and `vec_out` then holds the base with its low 3 bits replaced by the input number.
- R7: A command write of 0x60 + n clears in-service bit n and no other.
- R8: A command write of 0x20 clears the lowest-indexed set in-service bit.
- R9: When bit 1 of the mode word is 1, the first acknowledge pulse sets no in-service bit.
- R10: If no unmasked request outranks the in-service bits at the first pulse, the vector reports input 7 and the in-service register is unchanged.
- R11: With `role_master` high, a serviced input whose bit is set in the cascade word produces `cas_active` for one cycle with `cas_code` = input number, instead of `vec_valid`. `slave_id` always shows the low 3 bits of the cascade word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| irq_lines | input | 8 | Interrupt request inputs, index 0 highest priority |
| role_master | input | 1 | High when this controller is a cascade master |
| ack_pulse | input | 1 | One-cycle acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector byte valid for one cycle |
| vec_out | output | 8 | Vector byte |
| cas_active | output | 1 | Serviced input is routed to a downstream controller |
| cas_code | output | 3 | Input number of the routed request |
| slave_id | output | 3 | Identity taken from the cascade word |

## Verification
The hardest situation to reach is the spurious acknowledge. A request must be seen on the interrupt output, then withdrawn or masked before the processor's first pulse arrives. The bench raises a line, waits for the output, drops the line, and only then issues both pulses. It repeats this with the input masked. The nested case also needs care: a higher-priority input is raised while a lower one is still in service, so that end-of-interrupt commands meet an in-service register with two bits set.

// File: rtl/pic_pkg.sv
// Package: shared constants and types for the interrupt controller.
// Assumes an 8-bit register port; command decode fields are fixed here.
package pic_pkg;
    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_W2   = 2'd1,
        ST_W3   = 2'd2,
        ST_W4   = 2'd3
    } cfg_state_t;

    localparam logic [2:0] EOI_NONSPEC = 3'b001;
    localparam logic [2:0] EOI_SPEC    = 3'b011;
    localparam logic [1:0] CMD_OCW2    = 2'b00;
    localparam logic [1:0] CMD_OCW3    = 2'b01;
endpackage

// File: rtl/pic_cfg_regs.sv
// Configuration and command decoder: runs the multi-word setup sequence,
// holds mask, vector base, cascade word, auto-EOI and read select, and
// emits one-cycle end-of-interrupt strobes. Assumes one write per cycle.
module pic_cfg_regs
    import pic_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic             ready,
    output logic [DW-1:0]    imr,
    output logic [DW-1:0]    vec_base,
    output logic [DW-1:0]    cas_map,
    output logic             aeoi,
    output logic             sel_isr,
    output logic             flush,
    output logic             eoi_spec,
    output logic             eoi_nonspec,
    output logic [IDX_W-1:0] eoi_idx
);
    cfg_state_t state_q;
    logic       need_w3_q;
    logic       need_w4_q;
    logic       cmd_wr;
    logic       dat_wr;

    // Split writes by address.
    always_comb begin
        cmd_wr = bus_wr & ~bus_addr;
        dat_wr = bus_wr & bus_addr;
    end

    // Decode start and end-of-interrupt commands for neighbouring blocks.
    always_comb begin
        flush       = cmd_wr & bus_wdata[4];
        eoi_spec    = cmd_wr & ready & (bus_wdata[4:3] == CMD_OCW2)
                      & (bus_wdata[7:5] == EOI_SPEC);
        eoi_nonspec = cmd_wr & ready & (bus_wdata[4:3] == CMD_OCW2)
                      & (bus_wdata[7:5] == EOI_NONSPEC);
        eoi_idx     = bus_wdata[IDX_W-1:0];
    end

    // Setup sequence, mask and read-select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OPEN;
            ready     <= 1'b0;
            need_w3_q <= 1'b0;
            need_w4_q <= 1'b0;
            vec_base  <= '0;
            cas_map   <= '0;
            aeoi      <= 1'b0;
            sel_isr   <= 1'b0;
            imr       <= '1;
        end else if (flush) begin
            state_q   <= ST_W2;
            ready     <= 1'b0;
            need_w3_q <= ~bus_wdata[1];
            need_w4_q <= bus_wdata[0];
            cas_map   <= '0;
            aeoi      <= 1'b0;
            sel_isr   <= 1'b0;
        end else if (cmd_wr && ready && bus_wdata[4:3] == CMD_OCW3 && bus_wdata[1]) begin
            sel_isr <= bus_wdata[0];
        end else if (dat_wr) begin
            unique case (state_q)
                ST_OPEN: imr <= bus_wdata;
                ST_W2: begin
                    vec_base <= bus_wdata;
                    if (need_w3_q) begin
                        state_q <= ST_W3;
                    end else if (need_w4_q) begin
                        state_q <= ST_W4;
                    end else begin
                        state_q <= ST_OPEN;
                        ready   <= 1'b1;
                    end
                end
                ST_W3: begin
                    cas_map <= bus_wdata;
                    if (need_w4_q) begin
                        state_q <= ST_W4;
                    end else begin
                        state_q <= ST_OPEN;
                        ready   <= 1'b1;
                    end
                end
                ST_W4: begin
                    aeoi    <= bus_wdata[1];
                    state_q <= ST_OPEN;
                    ready   <= 1'b1;
                end
                default: state_q <= ST_OPEN;
            endcase
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
// Request register: each bit sets on a rising input edge, drops when the
// line falls, and clears when acknowledged or when setup restarts.
// Assumes inputs are already synchronous to clk.
module pic_req_latch #(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    lines,
    input  logic             flush,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [DW-1:0]    irr
);
    logic [DW-1:0] prev_q;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    for (genvar g = 0; g < DW; g++) begin : g_bit
        // Per-input request bit with edge set and level hold.
        always_ff @(posedge clk) begin
            if (!rst_n || flush)
                irr[g] <= 1'b0;
            else if (clr_en && clr_idx == IDX_W'(g))
                irr[g] <= 1'b0;
            else
                irr[g] <= lines[g] & (irr[g] | ~prev_q[g]);
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// Fixed-priority resolver: finds the highest unmasked request that
// outranks every in-service bit, and the highest in-service bit.
// Purely combinational; index 0 is the highest priority.
module pic_resolver #(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic [DW-1:0]    irr,
    input  logic [DW-1:0]    imr,
    input  logic [DW-1:0]    isr,
    output logic             cand_any,
    output logic [IDX_W-1:0] cand_idx,
    output logic             hi_isr_any,
    output logic [IDX_W-1:0] hi_isr_idx
);
    logic [DW-1:0] allow;
    logic [DW-1:0] cand;

    // Inputs at or below the highest in-service level are blocked.
    always_comb begin
        logic blk;
        blk = 1'b0;
        for (int i = 0; i < DW; i++) begin
            blk      = blk | isr[i];
            allow[i] = ~blk;
        end
        cand = irr & ~imr & allow;
    end

    // Lowest-index pick for both the candidate and the in-service bit.
    always_comb begin
        cand_idx   = '0;
        hi_isr_idx = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (cand[i]) cand_idx   = IDX_W'(i);
            if (isr[i])  hi_isr_idx = IDX_W'(i);
        end
        cand_any   = |cand;
        hi_isr_any = |isr;
    end
endmodule

// File: rtl/pic_ack_seq.sv
// Acknowledge sequencer and in-service register: the first pulse commits
// the winner (or marks spurious), the second delivers the vector or the
// cascade route. Assumes pulses alternate first/second.
module pic_ack_seq #(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_pulse,
    input  logic                ready,
    input  logic                cand_any,
    input  logic [IDX_W-1:0]    cand_idx,
    input  logic                aeoi,
    input  logic [DW-IDX_W-1:0] base_hi,
    input  logic [DW-1:0]       cas_map,
    input  logic                role_master,
    input  logic                flush,
    input  logic                eoi_spec,
    input  logic                eoi_nonspec,
    input  logic [IDX_W-1:0]    eoi_idx,
    input  logic                hi_isr_any,
    input  logic [IDX_W-1:0]    hi_isr_idx,
    output logic [DW-1:0]       isr,
    output logic                phase,
    output logic                irr_clr,
    output logic [IDX_W-1:0]    irr_clr_idx,
    output logic [DW-1:0]       vec_out,
    output logic                vec_valid,
    output logic                cas_active,
    output logic [IDX_W-1:0]    cas_code
);
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(DW - 1);

    logic             first_p;
    logic             second_p;
    logic             take;
    logic             routed;
    logic [IDX_W-1:0] svc_q;
    logic             spur_q;
    logic [DW-1:0]    set_v;
    logic [DW-1:0]    clr_v;

    // Classify the pulse and form in-service set/clear vectors.
    always_comb begin
        first_p     = ack_pulse & ~phase;
        second_p    = ack_pulse & phase;
        take        = first_p & ready & cand_any;
        irr_clr     = take;
        irr_clr_idx = cand_idx;
        set_v       = (take && !aeoi) ? (DW'(1) << cand_idx) : '0;
        if (eoi_spec)
            clr_v = DW'(1) << eoi_idx;
        else if (eoi_nonspec && hi_isr_any)
            clr_v = DW'(1) << hi_isr_idx;
        else
            clr_v = '0;
        routed = role_master & ~spur_q & cas_map[svc_q];
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) isr <= '0;
        else                 isr <= (isr & ~clr_v) | set_v;
    end

    // Pulse phase and captured service number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= 1'b0;
            svc_q  <= '0;
            spur_q <= 1'b0;
        end else if (first_p) begin
            phase  <= 1'b1;
            svc_q  <= take ? cand_idx : SPUR_IDX;
            spur_q <= ~take;
        end else if (second_p) begin
            phase  <= 1'b0;
        end
    end

    // Vector or cascade-route output for one cycle after the second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid  <= 1'b0;
            vec_out    <= '0;
            cas_active <= 1'b0;
            cas_code   <= '0;
        end else begin
            vec_valid  <= second_p & ~routed;
            cas_active <= second_p & routed;
            if (second_p) begin
                vec_out  <= {base_hi, svc_q};
                cas_code <= svc_q;
            end
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
// Top: eight-input priority interrupt controller with a two-address
// register port and a two-pulse acknowledge. Connects the decoder,
// request latch, resolver and acknowledge sequencer.
module pic8_ctrl #(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [DW-1:0]    irq_lines,
    input  logic             role_master,
    input  logic             ack_pulse,
    output logic             int_out,
    output logic             vec_valid,
    output logic [DW-1:0]    vec_out,
    output logic             cas_active,
    output logic [IDX_W-1:0] cas_code,
    output logic [IDX_W-1:0] slave_id
);
    logic             ready_w, aeoi_w, sel_isr_w, flush_w;
    logic             eoi_spec_w, eoi_nonspec_w;
    logic [IDX_W-1:0] eoi_idx_w;
    logic [DW-1:0]    imr_w, irr_w, isr_w, base_w, map_w;
    logic             cand_any_w, hi_any_w, phase_w, irr_clr_w;
    logic [IDX_W-1:0] cand_idx_w, hi_idx_w, irr_clr_idx_w;

    pic_cfg_regs #(.DW(DW), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ready(ready_w), .imr(imr_w),
        .vec_base(base_w), .cas_map(map_w), .aeoi(aeoi_w),
        .sel_isr(sel_isr_w), .flush(flush_w), .eoi_spec(eoi_spec_w),
        .eoi_nonspec(eoi_nonspec_w), .eoi_idx(eoi_idx_w)
    );

    pic_req_latch #(.DW(DW), .IDX_W(IDX_W)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .flush(flush_w),
        .clr_en(irr_clr_w), .clr_idx(irr_clr_idx_w), .irr(irr_w)
    );

    pic_resolver #(.DW(DW), .IDX_W(IDX_W)) u_res (
        .irr(irr_w), .imr(imr_w), .isr(isr_w), .cand_any(cand_any_w),
        .cand_idx(cand_idx_w), .hi_isr_any(hi_any_w), .hi_isr_idx(hi_idx_w)
    );

    pic_ack_seq #(.DW(DW), .IDX_W(IDX_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_pulse(ack_pulse), .ready(ready_w),
        .cand_any(cand_any_w), .cand_idx(cand_idx_w), .aeoi(aeoi_w),
        .base_hi(base_w[DW-1:IDX_W]), .cas_map(map_w),
        .role_master(role_master), .flush(flush_w), .eoi_spec(eoi_spec_w),
        .eoi_nonspec(eoi_nonspec_w), .eoi_idx(eoi_idx_w),
        .hi_isr_any(hi_any_w), .hi_isr_idx(hi_idx_w), .isr(isr_w),
        .phase(phase_w), .irr_clr(irr_clr_w), .irr_clr_idx(irr_clr_idx_w),
        .vec_out(vec_out), .vec_valid(vec_valid), .cas_active(cas_active),
        .cas_code(cas_code)
    );

    // Interrupt output and register read mux.
    always_comb begin
        int_out  = ready_w & ~phase_w & cand_any_w;
        slave_id = map_w[IDX_W-1:0];
        if (!bus_rd)       bus_rdata = '0;
        else if (bus_addr) bus_rdata = imr_w;
        else if (sel_isr_w) bus_rdata = isr_w;
        else               bus_rdata = irr_w;
    end
endmodule

// File: rtl/pic8_chk.sv
// Checker: temporal properties of the controller, bound to the top.
module pic8_chk #(
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          int_out,
    input logic          vec_valid,
    input logic          cas_active,
    input logic          ack_pulse,
    input logic          bus_wr,
    input logic          bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] isr,
    input logic [DW-1:0] irr,
    input logic [DW-1:0] imr,
    input logic          ready
);
    a_r2_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);

    a_r4_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~imr));

    a_r6_vec_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_pulse));

    a_r11_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && cas_active));

    a_r7_spec_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && ready && !ack_pulse && bus_wdata[7:3] == 5'b01100)
        |=> !isr[$past(bus_wdata[IDX_W-1:0])]);
endmodule

bind pic8_ctrl pic8_chk #(.DW(DW), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .int_out(int_out), .vec_valid(vec_valid),
    .cas_active(cas_active), .ack_pulse(ack_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .isr(isr_w), .irr(irr_w),
    .imr(imr_w), .ready(ready_w)
);

// File: tb/sim_pic8_ctrl.sv
`timescale 1ns/1ps
module sim_pic8_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq = 8'h00;
    logic       role_master = 1'b1;
    logic       ack_pulse = 1'b0;
    logic       int_out, vec_valid, cas_active;
    logic [7:0] vec_out;
    logic [2:0] cas_code, slave_id;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq), .role_master(role_master), .ack_pulse(ack_pulse),
        .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out),
        .cas_active(cas_active), .cas_code(cas_code), .slave_id(slave_id)
    );

    // Behavioural reference model state.
    bit [7:0] m_irr, m_isr, m_imr, m_base, m_map, m_prev;
    bit       m_ready, m_aeoi, m_sel, m_n3, m_n4, m_phase, m_spur;
    int       m_st, m_idx;
    bit       m_vv, m_ca;
    bit [7:0] m_vec;
    int       m_cc;

    function automatic int cand_of();
        bit blk = 0;
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) blk = 1;
            if (!blk && m_irr[i] && !m_imr[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_base = 0; m_map = 0; m_prev = 0;
            m_ready = 0; m_aeoi = 0; m_sel = 0; m_n3 = 0; m_n4 = 0; m_phase = 0;
            m_spur = 0; m_st = 0; m_idx = 0; m_vv = 0; m_ca = 0; m_vec = 0; m_cc = 0;
        end else begin
            int c, h;
            bit [7:0] nirr, nisr;
            bit cmd, dat, first, second, flush;
            c = m_ready ? cand_of() : -1;
            h = -1;
            for (int i = 7; i >= 0; i--) if (m_isr[i]) h = i;
            cmd = bus_wr && !bus_addr; dat = bus_wr && bus_addr;
            flush = cmd && bus_wdata[4];
            first = ack_pulse && !m_phase; second = ack_pulse && m_phase;
            for (int i = 0; i < 8; i++) nirr[i] = irq[i] && (m_irr[i] || !m_prev[i]);
            nisr = m_isr;
            if (first && c >= 0) begin
                nirr[c] = 0;
                if (!m_aeoi) nisr[c] = 1;
            end
            if (cmd && m_ready && !bus_wdata[4] && !bus_wdata[3]) begin
                if (bus_wdata[7:5] == 3'd3) nisr[bus_wdata[2:0]] = 0;
                else if (bus_wdata[7:5] == 3'd1 && h >= 0) nisr[h] = 0;
            end
            if (flush) begin nirr = 0; nisr = 0; end
            m_vv = 0; m_ca = 0;
            if (second) begin
                if (role_master && !m_spur && m_map[m_idx]) begin m_ca = 1; m_cc = m_idx; end
                else begin m_vv = 1; m_vec = {m_base[7:3], 3'(m_idx)}; end
                m_phase = 0;
            end else if (first) begin
                m_phase = 1; m_idx = (c >= 0) ? c : 7; m_spur = (c < 0);
            end
            if (flush) begin
                m_st = 1; m_ready = 0; m_n3 = !bus_wdata[1]; m_n4 = bus_wdata[0];
                m_map = 0; m_aeoi = 0; m_sel = 0;
            end else if (cmd && m_ready && bus_wdata[4:3] == 2'b01 && bus_wdata[1]) begin
                m_sel = bus_wdata[0];
            end else if (dat) begin
                case (m_st)
                    0: m_imr = bus_wdata;
                    1: begin m_base = bus_wdata; m_st = m_n3 ? 2 : (m_n4 ? 3 : 0); end
                    2: begin m_map = bus_wdata; m_st = m_n4 ? 3 : 0; end
                    default: begin m_aeoi = bus_wdata[1]; m_st = 0; end
                endcase
                if (m_st == 0) m_ready = 1;
            end
            m_irr = nirr; m_isr = nisr; m_prev = irq;
        end
    end

    // Compare outputs with the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit ei;
            ei = m_ready && !m_phase && (cand_of() >= 0);
            n_chk++;
            if (int_out !== ei) begin
                n_fail++; $display("FAIL R4 int_out act=%0b exp=%0b t=%0t", int_out, ei, $time);
            end
            n_chk++;
            if (vec_valid !== m_vv || (m_vv && vec_out !== m_vec)) begin
                n_fail++; $display("FAIL R6 vec act=%0b/%h exp=%0b/%h", vec_valid, vec_out, m_vv, m_vec);
            end
            n_chk++;
            if (cas_active !== m_ca || (m_ca && cas_code !== 3'(m_cc))) begin
                n_fail++; $display("FAIL R11 cas act=%0b/%0d exp=%0b/%0d", cas_active, cas_code, m_ca, m_cc);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++; $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req);
        bus_rd = 1; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic ack2();
        ack_pulse = 1; step(1); ack_pulse = 0; step(1);
        ack_pulse = 1; step(1); ack_pulse = 0;
    endtask

    task automatic ack_vec(input logic [7:0] exp, input string req);
        ack2();
        chk(req, {7'd0, vec_valid}, 8'h01);
        chk(req, vec_out, exp);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        rd(1, 8'hFF, "R1 mask after reset");
        irq = 8'h08; step(2);
        chk("R2 unconfigured quiet", {7'd0, int_out}, 8'h00);
        irq = 8'h00;
        wr(0, 8'h11); wr(1, 8'h20);
        chk("R2 quiet during setup", {7'd0, int_out}, 8'h00);
        wr(1, 8'h04); wr(1, 8'h01); wr(1, 8'h00);
        rd(0, 8'h00, "R5 default request read");
        irq[5] = 1; step(1);
        chk("R4 request raises int", {7'd0, int_out}, 8'h01);
        rd(0, 8'h20, "R5 request read");
        ack_vec(8'h25, "R6 vector");
        wr(0, 8'h0B); rd(0, 8'h20, "R6 in-service set");
        wr(0, 8'h0A); rd(0, 8'h00, "R6 request cleared");
        irq[6] = 1; step(1);
        chk("R4 lower priority blocked", {7'd0, int_out}, 8'h00);
        irq[1] = 1; step(1);
        chk("R4 nesting", {7'd0, int_out}, 8'h01);
        ack_vec(8'h21, "R6 nested vector");
        wr(0, 8'h0B); rd(0, 8'h22, "R5 in-service read");
        wr(0, 8'h61); rd(0, 8'h20, "R7 specific eoi");
        wr(0, 8'h20); rd(0, 8'h00, "R8 nonspecific eoi");
        chk("R8 pending now eligible", {7'd0, int_out}, 8'h01);
        ack_vec(8'h26, "R6 vector six");
        wr(0, 8'h66); irq = 0; step(1);
        wr(1, 8'h10); irq[4] = 1; step(2);
        chk("R3 masked quiet", {7'd0, int_out}, 8'h00);
        rd(1, 8'h10, "R3 mask read");
        wr(0, 8'h0A); rd(0, 8'h10, "R3 masked request held");
        wr(1, 8'h00);
        chk("R3 unmask raises", {7'd0, int_out}, 8'h01);
        ack_vec(8'h24, "R6 vector four");
        wr(0, 8'h64); irq = 0; step(1);
        irq[0] = 1; step(1); irq[0] = 0; step(1);
        chk("R4 withdrawn request", {7'd0, int_out}, 8'h00);
        ack_vec(8'h27, "R10 spurious vector");
        wr(0, 8'h0B); rd(0, 8'h00, "R10 in-service unchanged");
        wr(1, 8'h01); irq[0] = 1; step(1);
        ack_vec(8'h27, "R10 masked spurious");
        irq = 0; wr(1, 8'h00);
        irq[2] = 1; step(1);
        ack2();
        chk("R11 routed", {7'd0, cas_active}, 8'h01);
        chk("R11 route code", {5'd0, cas_code}, 8'h02);
        chk("R11 no vector", {7'd0, vec_valid}, 8'h00);
        wr(0, 8'h62); irq = 0; step(1);
        role_master = 0;
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h03);
        chk("R11 slave id", {5'd0, slave_id}, 8'h02);
        irq[2] = 1; step(1);
        ack_vec(8'h2A, "R6 slave vector");
        wr(0, 8'h0B); rd(0, 8'h00, "R9 auto eoi leaves no bit");
        irq = 0; step(1);
        wr(0, 8'h12); wr(1, 8'h40);
        irq[0] = 1; step(1);
        ack_vec(8'h40, "R2 single mode base only");
        irq = 0; step(1);
        wr(0, 8'h13); irq[7] = 1; step(1);
        chk("R2 quiet before mode word", {7'd0, int_out}, 8'h00);
        wr(1, 8'h48); wr(1, 8'h00);
        chk("R2 ready after mode word", {7'd0, int_out}, 8'h01);
        ack_vec(8'h4F, "R2 vector after skip");
        irq = 0; step(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule